// File: doc/BRIEF.md
# Masked Burst Address Generator

This block is the address front end of one memory port. Each clock it decides where the port's internal word address comes from. It can take the address straight from the external address pins. It can load that address into a burst counter, then step the counter once per clock, clear it, or hold it. A stepping counter stays inside a region chosen by a programmable mask. Counter bits whose mask bit is 1 take part in the count. Counter bits whose mask bit is 0 keep their loaded value. With a mask of contiguous low ones, a burst therefore cycles through an aligned power-of-two window.

The address pins are shared and bidirectional. For a readback, the block drives either the current counter value or the mask value back onto those pins and raises the pin output enable. While a readback is in progress, nothing is taken from the pins. The mask register is written from the address pins on a strobe, and reset leaves it at all ones so that the counter spans the whole array.

Top module: `burst_addr_gen`

## Requirements
- R1: After a synchronous reset, the internal address is 0, the mask is all ones, the pin output enable is low, and the block is in pass-through mode.
- R2: When `cnt_clr` is high at a rising edge, the internal address becomes 0, whatever the other controls are. This also enters counter mode.
- R3: When `load_n` is low, `cnt_clr` is low and no readback is requested, the internal address takes `addr_i` at the edge. This enters counter mode.
- R4: When `incr` is high and neither clear nor an accepted load is active, the counter advances by one inside the masked bits. The lowest masked bit that is 0 is set, and the masked bits below it are cleared.
- R5: With an all-ones mask, a step from the all-ones address wraps to 0.
- R6: Bits whose mask bit is 0 are never changed by a step, so a burst wraps within its aligned region (mask 0x0F cycles the low nibble only).
- R7: In counter mode, with no clear, no accepted load and no increment, the internal address holds its value.
- R8: In pass-through mode, with no clear, load, increment or readback, the internal address takes `addr_i` at each edge.
- R9: When `mask_wr` is high and no readback is requested, the mask register takes `addr_i` at the edge.
- R10: `addr_oe` is high exactly while `rd_cnt` or `rd_mask` is high. `addr_o` shows the counter when `rd_cnt` is high (counter wins if both are high), otherwise the mask.
- R11: During a readback, `addr_i` is not sampled. Load, mask write and pass-through have no effect, while clear and increment still act.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Value seen on the address pins |
| load_n | input | 1 | Active-low counter load from the pins |
| incr | input | 1 | Step the counter this edge |
| cnt_clr | input | 1 | Clear the counter to zero |
| mask_wr | input | 1 | Write the mask register from the pins |
| rd_cnt | input | 1 | Drive the counter value onto the pins |
| rd_mask | input | 1 | Drive the mask value onto the pins |
| addr_int | output | AW | Internal word address to the array |
| addr_o | output | AW | Value driven onto the address pins during readback |
| addr_oe | output | 1 | Output enable for the address pins |

## Verification
The bench goes after several corner cases, each with a visible failure mode:
- Wrap at the top of the array and wrap inside a partial mask. A plain adder would carry into the fixed bits and leave the region.
- A mask with a hole in it. A design that treats the mask as a simple limit would skip the wrong bits.
- Simultaneous clear, load and increment. A wrong priority loads or steps where it should clear.
- Loads and mask writes issued during a readback. A design that samples the pins then would capture its own driven value.
- The readback with both selects high, and the change from pass-through to hold after the first load. These expose swapped readback priority and a counter that keeps following the pins.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Operation applied to the address register at the next edge
    typedef enum logic [2:0] {
        OP_PASS  = 3'd0,
        OP_HOLD  = 3'd1,
        OP_STEP  = 3'd2,
        OP_LOAD  = 3'd3,
        OP_CLEAR = 3'd4
    } cnt_op_e;

    // Source driven onto the address pins
    typedef enum logic [1:0] {
        RB_NONE = 2'd0,
        RB_CNT  = 2'd1,
        RB_MASK = 2'd2
    } rb_sel_e;

    // Decoded control bundle handed to the counter core
    typedef struct packed {
        logic clr;
        logic load;
        logic step;
        logic rd_any;
    } ctl_t;

    function automatic ctl_t decode_ctl(
        input logic cnt_clr,
        input logic load_n,
        input logic incr,
        input logic rd_cnt,
        input logic rd_mask
    );
        ctl_t c;
        c.clr    = cnt_clr;
        c.load   = ~load_n;
        c.step   = incr;
        c.rd_any = rd_cnt | rd_mask;
        return c;
    endfunction

    // Priority: clear, accepted load, step, then readback hold, hold, pass
    function automatic cnt_op_e pick_op(input ctl_t c, input logic counting);
        cnt_op_e op;
        if (c.clr)
            op = OP_CLEAR;
        else if (c.load && !c.rd_any)
            op = OP_LOAD;
        else if (c.step)
            op = OP_STEP;
        else if (c.rd_any || counting)
            op = OP_HOLD;
        else
            op = OP_PASS;
        return op;
    endfunction

    function automatic rb_sel_e pick_rb(input logic rd_cnt, input logic rd_mask);
        rb_sel_e s;
        if (rd_cnt)
            s = RB_CNT;
        else if (rd_mask)
            s = RB_MASK;
        else
            s = RB_NONE;
        return s;
    endfunction

endpackage

// File: rtl/burst_mask_reg.sv
module burst_mask_reg
    import burst_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          rd_any,
    input  logic [AW-1:0] pins,
    output logic [AW-1:0] mask
);

    localparam logic [AW-1:0] MASK_RESET = {AW{1'b1}};

    logic          take;
    logic [AW-1:0] mask_q;

    assign take = wr & ~rd_any;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= MASK_RESET;
        else if (take)
            mask_q <= pins;
    end

    assign mask = mask_q;

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr && !rd_any) |=> (mask == $past(pins))); // R9

    AST_MASK_RB_BLOCK: assert property (@(posedge clk) disable iff (rst)
        rd_any |=> $stable(mask)); // R11

endmodule

// File: rtl/burst_counter_core.sv
module burst_counter_core
    import burst_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          ctl,
    input  logic [AW-1:0] pins,
    input  logic [AW-1:0] mask,
    output logic [AW-1:0] cnt,
    output logic          counting
);

    localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};
    localparam logic [AW-1:0] ONE      = {{(AW-1){1'b0}}, 1'b1};

    cnt_op_e       op;
    logic [AW-1:0] cnt_q;
    logic [AW-1:0] cnt_d;
    logic [AW-1:0] stepped;
    logic          mode_q;
    logic          mode_d;

    // Carry skips the fixed bits: fixed bits are forced to 1 before the add
    // so the carry ripples through them, then the sum is masked back.
    function automatic logic [AW-1:0] masked_step(
        input logic [AW-1:0] v,
        input logic [AW-1:0] m
    );
        logic [AW-1:0] sum;
        sum = (v | ~m) + ONE;
        return (sum & m) | (v & ~m);
    endfunction

    always_comb begin
        op      = pick_op(ctl, mode_q);
        stepped = masked_step(cnt_q, mask);
        cnt_d   = cnt_q;
        mode_d  = mode_q;
        unique case (op)
            OP_CLEAR: begin
                cnt_d  = '0;
                mode_d = 1'b1;
            end
            OP_LOAD: begin
                cnt_d  = pins;
                mode_d = 1'b1;
            end
            OP_STEP:  cnt_d = stepped;
            OP_HOLD:  cnt_d = cnt_q;
            OP_PASS:  cnt_d = pins;
            default:  cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            mode_q <= mode_d;
        end
    end

    assign cnt      = cnt_q;
    assign counting = mode_q;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (cnt == '0)); // R2

    AST_LOAD_TAKES_PINS: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && ctl.load && !ctl.rd_any) |=> (cnt == $past(pins))); // R3

    AST_STEP_KEEPS_FIXED: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && !(ctl.load && !ctl.rd_any) && ctl.step)
        |=> ((cnt & ~$past(mask)) == ($past(cnt) & ~$past(mask)))); // R6

    AST_FULL_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && !(ctl.load && !ctl.rd_any) && ctl.step
         && mask == ALL_ONES && cnt == ALL_ONES) |=> (cnt == '0)); // R5

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && !ctl.step && (counting || ctl.rd_any)
         && !(ctl.load && !ctl.rd_any)) |=> $stable(cnt)); // R7

    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
        counting |=> counting); // R7

endmodule

// File: rtl/burst_readback_mux.sv
module burst_readback_mux
    import burst_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          rd_cnt,
    input  logic          rd_mask,
    input  logic [AW-1:0] cnt,
    input  logic [AW-1:0] mask,
    output logic [AW-1:0] bus_o,
    output logic          bus_oe
);

    rb_sel_e sel;

    always_comb begin
        sel = pick_rb(rd_cnt, rd_mask);
        unique case (sel)
            RB_CNT:  begin bus_o = cnt;  bus_oe = 1'b1; end
            RB_MASK: begin bus_o = mask; bus_oe = 1'b1; end
            default: begin bus_o = '0;   bus_oe = 1'b0; end
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_i,
    input  logic          load_n,
    input  logic          incr,
    input  logic          cnt_clr,
    input  logic          mask_wr,
    input  logic          rd_cnt,
    input  logic          rd_mask,
    output logic [AW-1:0] addr_int,
    output logic [AW-1:0] addr_o,
    output logic          addr_oe
);

    ctl_t          ctl;
    logic [AW-1:0] mask;
    logic [AW-1:0] cnt;
    logic          counting;

    assign ctl = decode_ctl(cnt_clr, load_n, incr, rd_cnt, rd_mask);

    burst_mask_reg #(.AW(AW)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr     (mask_wr),
        .rd_any (ctl.rd_any),
        .pins   (addr_i),
        .mask   (mask)
    );

    burst_counter_core #(.AW(AW)) u_core (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .pins     (addr_i),
        .mask     (mask),
        .cnt      (cnt),
        .counting (counting)
    );

    burst_readback_mux #(.AW(AW)) u_rb (
        .rd_cnt  (rd_cnt),
        .rd_mask (rd_mask),
        .cnt     (cnt),
        .mask    (mask),
        .bus_o   (addr_o),
        .bus_oe  (addr_oe)
    );

    assign addr_int = cnt;

    AST_RB_COUNTER_WINS: assert property (@(posedge clk) disable iff (rst)
        rd_cnt |-> (addr_oe && addr_o == addr_int)); // R10

    AST_RB_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!rd_cnt && !rd_mask) |-> !addr_oe); // R10

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (!counting && !cnt_clr && load_n && !incr && !rd_cnt && !rd_mask)
        |=> (addr_int == $past(addr_i))); // R8

endmodule

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_i;
    logic          load_n, incr, cnt_clr, mask_wr, rd_cnt, rd_mask;
    logic [AW-1:0] addr_int, addr_o;
    logic          addr_oe;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // reference state
    logic [AW-1:0] m_cnt;
    logic [AW-1:0] m_mask;
    bit            m_mode;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .addr_i(addr_i), .load_n(load_n), .incr(incr),
        .cnt_clr(cnt_clr), .mask_wr(mask_wr), .rd_cnt(rd_cnt), .rd_mask(rd_mask),
        .addr_int(addr_int), .addr_o(addr_o), .addr_oe(addr_oe)
    );

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] ref_step(input logic [AW-1:0] v, input logic [AW-1:0] m);
        logic [AW-1:0] r;
        r = v;
        for (int i = 0; i < AW; i++) begin
            if (m[i]) begin
                if (r[i]) r[i] = 1'b0;
                else begin
                    r[i] = 1'b1;
                    break;
                end
            end
        end
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1; addr_i = '0; load_n = 1; incr = 0; cnt_clr = 0;
        mask_wr = 0; rd_cnt = 0; rd_mask = 0;
        @(posedge clk); @(negedge clk);
        rst = 0;
        m_cnt = '0; m_mask = '1; m_mode = 0;
        #1;
        chk("R1 addr", addr_int, '0);
        chk("R1 oe", {{(AW-1){1'b0}}, addr_oe}, '0);
    endtask

    task automatic cyc(input logic clr, input logic ld_n, input logic inc,
                       input logic mwr, input logic rc, input logic rm,
                       input logic [AW-1:0] a);
        logic [AW-1:0] n;
        logic          rd;
        string         t;
        @(negedge clk);
        cnt_clr = clr; load_n = ld_n; incr = inc; mask_wr = mwr;
        rd_cnt = rc; rd_mask = rm; addr_i = a;
        #1;
        rd = rc | rm;
        chk("R10 oe", {{(AW-1){1'b0}}, addr_oe}, {{(AW-1){1'b0}}, rd});
        if (rd) chk("R10 bus", addr_o, rc ? m_cnt : m_mask);
        n = m_cnt;
        if (clr) begin
            n = '0; m_mode = 1; t = "R2";
        end else if (!ld_n && !rd) begin
            n = a; m_mode = 1; t = "R3";
        end else if (inc) begin
            n = ref_step(m_cnt, m_mask);
            if (m_mask != '1) t = "R6";
            else if (m_cnt == '1) t = "R5";
            else t = "R4";
        end else if (rd) begin
            t = "R11";
        end else if (m_mode) begin
            t = "R7";
        end else begin
            n = a; t = "R8";
        end
        if (mwr && !rd) m_mask = a;   // R9
        m_cnt = n;
        @(posedge clk);
        #1;
        chk(t, addr_int, m_cnt);
    endtask

    task automatic idle(input logic [AW-1:0] a);
        cyc(0, 1, 0, 0, 0, 0, a);
    endtask

    task automatic read_mask();
        cyc(0, 1, 0, 0, 0, 1, 8'h00);   // bus check against mask
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        read_mask();                        // R1 mask all ones via readback
        chk("R1 mask", addr_o, '1);
        // R8: pass-through before any load
        idle(8'h3C); idle(8'hA5); idle(8'h01);
        // R3 load then R7 hold while pins change
        cyc(0, 0, 0, 0, 0, 0, 8'hF0);
        idle(8'h11); idle(8'h22);
        // R4 steps with full mask, R5 wrap
        for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, 0, 0, 8'h00);
        cyc(0, 0, 0, 0, 0, 0, 8'hFE);
        cyc(0, 1, 1, 0, 0, 0, 8'h00);
        cyc(0, 1, 1, 0, 0, 0, 8'h00);       // R5 FF -> 00
        cyc(0, 1, 1, 0, 0, 0, 8'h00);
        // R2 clear beats load and step
        cyc(1, 0, 1, 0, 0, 0, 8'h77);
        // R9 mask write 0x0F, R6 aligned wrap
        cyc(0, 1, 0, 1, 0, 0, 8'h0F);
        read_mask();
        cyc(0, 0, 0, 0, 0, 0, 8'hAD);
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0, 0, 0, 8'h00);
        // R6 mask with a hole: 0x35
        cyc(0, 1, 0, 1, 0, 0, 8'h35);
        cyc(0, 0, 0, 0, 0, 0, 8'h80);
        for (int i = 0; i < 10; i++) cyc(0, 1, 1, 0, 0, 0, 8'h00);
        // R4 load wins over step
        cyc(0, 0, 1, 0, 0, 0, 8'h42);
        // R11 load and mask write ignored during readback
        cyc(0, 0, 0, 1, 1, 0, 8'h99);
        cyc(0, 0, 0, 1, 0, 1, 8'h66);
        read_mask();
        // R10 both selects: counter wins; R11 step still acts in readback
        cyc(0, 1, 0, 0, 1, 1, 8'h00);
        cyc(0, 1, 1, 0, 1, 0, 8'h00);
        cyc(1, 1, 0, 0, 0, 1, 8'h00);       // R2 clear during readback
        // R11 pass-through blocked by readback after fresh reset
        do_reset();
        idle(8'h5A);
        cyc(0, 1, 0, 0, 1, 0, 8'hC3);
        idle(8'h18);
        // mixed sweep
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r;
            r = 8'(($urandom) & 8'hFF);
            cyc(($urandom % 16) == 0, ($urandom % 6) != 0, ($urandom % 2) == 0,
                ($urandom % 12) == 0, ($urandom % 7) == 0, ($urandom % 7) == 0, r);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule